// File: doc/BRIEF.md
# Interrupt Flag Unit with Watch Timer

This unit gathers the interrupt requests of a small processor system into one flag register on the CPU bus and drives a single combined IRQ line. Five peripherals each deliver a one-cycle request pulse: timer 1, the port-1 external wake-up, timer 2, sound generator 1 and sound generator 2. The sixth source is a watch timer inside the unit. The watch timer counts strobes from a 32.768 kHz reference and raises its request either twice or once per second. Its rate is set by a write-only control register.

The interrupt service routine reads the flag register to find the pending causes. It acknowledges a cause by writing 0 to that cause's bit. Bits written as 1 are left untouched, so one write can acknowledge some causes without losing others. A new request that arrives in the same cycle as its own acknowledge is kept.

The same reference strobe also paces a non-maskable interrupt at 64 Hz. This is a one-cycle pulse on a pin of its own. It has no flag and does not affect IRQ.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, all six flags are 0, `irq` and `nmi` are 0, and the watch timer rate is 2 Hz. The watch timer and NMI tick counters restart from zero.
- R2: A one-cycle pulse on `ext_req[k]` sets flag bit k+1 at the next clock edge. The mapping is: bit 1 timer 1, bit 2 port-1 external, bit 3 timer 2, bit 4 sound generator 1, bit 5 sound generator 2. Bit 0 belongs to the watch timer.
- R3: A bus write to address 0x1003 clears every flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. No other event clears a flag.
- R4: If a source requests a flag in the same cycle as a write that would clear that flag, the flag ends up set.
- R5: `irq` is high whenever any flag is set. It falls only after a write to 0x1003 that clears the last pending flag.
- R6: A read at 0x1003 returns the flags in bits 5..0, with bits 7..6 reading as 0. A read of any other address returns 0.
- R7: Bit 1 of the control register at 0x1002 selects the watch timer rate: 0 gives 2 Hz and 1 gives 1 Hz. The other bits of a write to this register have no effect. Reading 0x1002 returns 0.
- R8: At 2 Hz, flag bit 0 is set on the strobe that completes each run of TICK_HZ/2 reference strobes. At 1 Hz, it is set only on the strobe that completes each run of TICK_HZ strobes, counted from reset.
- R9: `nmi` is a one-cycle pulse on every TICK_HZ/64-th reference strobe. It never sets a flag or raises `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe per 32.768 kHz reference period |
| bus_addr | input | 16 | CPU bus address |
| bus_wdata | input | 8 | CPU bus write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data, combinational from address and read strobe |
| ext_req | input | 5 | Request pulses from timer 1, port 1, timer 2, sound 1, sound 2 |
| irq | output | 1 | Combined interrupt request |
| nmi | output | 1 | 64 Hz non-maskable interrupt pulse |

## Verification
Several properties are checked on every cycle:
- A flag rises only after a request to it.
- A flag falls only after a write to the flag register.
- A requested flag is always set on the following cycle.
- `irq` drops only after such a write.
- `nmi` never lasts two cycles.
- The unused read-data bits stay at zero.

Other behaviour needs the bench's scenarios. These are the exact strobe count at which the watch timer fires in each rate, the 64 Hz NMI spacing, the bit mapping of the sources and the write-only behaviour of the control register.

// File: rtl/iflag_pkg.sv
package iflag_pkg;

  typedef enum logic {
    RATE_2HZ = 1'b0,
    RATE_1HZ = 1'b1
  } wt_rate_e;

  // Next state of a single flag: a request always wins over a clear.
  function automatic logic f_flag_next(input logic cur, input logic req,
                                       input logic clr);
    return req | (cur & ~clr);
  endfunction

  // Watch timer fires on the last strobe of a half or full second.
  function automatic logic f_wt_hit(input logic at_half, input logic at_full,
                                    input wt_rate_e rate);
    return at_full | (at_half & (rate == RATE_2HZ));
  endfunction

endpackage

// File: rtl/ifu_bus_decode.sv
module ifu_bus_decode #(
  parameter int ADDR_W    = 16,
  parameter int FLAG_ADDR = 'h1003,
  parameter int CTRL_ADDR = 'h1002
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              flag_wr,
  output logic              flag_rd,
  output logic              ctrl_wr
);
  logic hit_flag;
  logic hit_ctrl;

  assign hit_flag = (addr == ADDR_W'(FLAG_ADDR));
  assign hit_ctrl = (addr == ADDR_W'(CTRL_ADDR));
  assign flag_wr  = wr & hit_flag;
  assign flag_rd  = rd & hit_flag;
  assign ctrl_wr  = wr & hit_ctrl;
endmodule

// File: rtl/ifu_watch_timer.sv
module ifu_watch_timer
  import iflag_pkg::*;
#(
  parameter int TICK_HZ = 32768
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_en,
  input  wt_rate_e rate,
  output logic     wt_fire,
  output logic     nmi_pulse
);
  localparam int HALF_CNT = TICK_HZ / 2;
  localparam int NMI_CNT  = TICK_HZ / 64;
  localparam int CW       = $clog2(TICK_HZ);
  localparam int NW       = (NMI_CNT > 2) ? $clog2(NMI_CNT) : 1;

  logic [CW-1:0] sec_cnt;
  logic [NW-1:0] nmi_cnt;
  logic          at_half;
  logic          at_full;
  logic          nmi_last;

  assign at_half  = (sec_cnt == CW'(HALF_CNT - 1));
  assign at_full  = (sec_cnt == CW'(TICK_HZ - 1));
  assign nmi_last = (nmi_cnt == NW'(NMI_CNT - 1));
  assign wt_fire  = tick_en & f_wt_hit(at_half, at_full, rate);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_cnt <= '0;
    end else if (tick_en) begin
      sec_cnt <= at_full ? '0 : sec_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_cnt   <= '0;
      nmi_pulse <= 1'b0;
    end else begin
      nmi_pulse <= tick_en & nmi_last;
      if (tick_en) begin
        nmi_cnt <= nmi_last ? '0 : nmi_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ifu_flag_bank.sv
module ifu_flag_bank
  import iflag_pkg::*;
#(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] req,
  input  logic          wr,
  input  logic [NF-1:0] keep_mask,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    logic clr_i;
    assign clr_i = wr & ~keep_mask[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else begin
        flags[i] <= f_flag_next(flags[i], req[i], clr_i);
      end
    end
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import iflag_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_EXT   = 5,
  parameter int TICK_HZ   = 32768,
  parameter int FLAG_ADDR = 'h1003,
  parameter int CTRL_ADDR = 'h1002,
  parameter int RATE_BIT  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  input  logic               bus_wr,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_EXT-1:0] ext_req,
  output logic               irq,
  output logic               nmi
);
  localparam int NUM_FLAGS = NUM_EXT + 1;

  logic                 flag_wr;
  logic                 flag_rd;
  logic                 ctrl_wr;
  logic                 wt_fire;
  wt_rate_e             rate;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;

  ifu_bus_decode #(
    .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .flag_wr(flag_wr), .flag_rd(flag_rd), .ctrl_wr(ctrl_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate <= RATE_2HZ;
    end else if (ctrl_wr) begin
      rate <= wt_rate_e'(bus_wdata[RATE_BIT]);
    end
  end

  ifu_watch_timer #(.TICK_HZ(TICK_HZ)) u_wt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate(rate),
    .wt_fire(wt_fire), .nmi_pulse(nmi)
  );

  assign set_vec = {ext_req, wt_fire};

  ifu_flag_bank #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .req(set_vec), .wr(flag_wr),
    .keep_mask(bus_wdata[NUM_FLAGS-1:0]), .flags(flags)
  );

  assign irq       = |flags;
  assign bus_rdata = flag_rd ? DATA_W'(flags) : '0;
endmodule

// File: rtl/ifu_checker.sv
module ifu_checker #(
  parameter int NF = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NF-1:0] flags,
  input logic [NF-1:0] set_vec,
  input logic          flag_wr,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic          nmi
);
  // R2/R3: a flag can only rise after a request to it
  a_r2_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

  // R3: a flag can only fall after a write to the flag register
  a_r3_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((~flags & $past(flags)) == '0));

  // R4: a requested flag is set in the next cycle, whatever the bus does
  a_r4_req_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // R5: irq drops only after a flag-register write
  a_r5_irq_drop_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(flag_wr));

  // R6: unused read-data bits are zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NF] == '0);

  // R9: nmi lasts a single cycle
  a_r9_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi);
endmodule

bind irq_flag_unit ifu_checker #(.NF(NUM_FLAGS), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .set_vec(set_vec),
  .flag_wr(flag_wr), .rdata(bus_rdata), .irq(irq), .nmi(nmi)
);

// File: tb/test_irq_flag_unit.sv
module test_irq_flag_unit;
  localparam int TICK_HZ = 256;
  localparam logic [15:0] A_FLAG = 16'h1003;
  localparam logic [15:0] A_CTRL = 16'h1002;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic [4:0]  ext_req = '0;
  logic        irq;
  logic        nmi;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_flag_unit #(.TICK_HZ(TICK_HZ)) i_irq_flag_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .ext_req(ext_req), .irq(irq), .nmi(nmi)
  );

  // {ext_req[4:0], do_write, wdata[7:0], expected flags[5:0]}
  localparam logic [19:0] VEC [8] = '{
    {5'b00001, 1'b0, 8'h00, 6'b000010},   // R2 timer 1 -> bit 1
    {5'b10100, 1'b0, 8'h00, 6'b101010},   // R2 timer 2, sound 2
    {5'b00000, 1'b1, 8'hFF, 6'b101010},   // R3 all ones keep
    {5'b00000, 1'b1, 8'hF7, 6'b100010},   // R3 clear bit 3 only
    {5'b00010, 1'b1, 8'h00, 6'b000100},   // R4 port 1 set beats clear
    {5'b00000, 1'b1, 8'h00, 6'b000000},   // R5 all cleared
    {5'b11111, 1'b0, 8'h00, 6'b111110},   // R2 every external source
    {5'b00000, 1'b1, 8'hC0, 6'b000000}    // R3 zeros in low bits clear
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(A_FLAG, rd);
    check("R1 flags", rd, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 nmi", nmi, 1'b0);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      ext_req   = VEC[v][19:15];
      bus_wr    = VEC[v][14];
      bus_addr  = A_FLAG;
      bus_wdata = VEC[v][13:6];
      @(negedge clk);
      ext_req = '0; bus_wr = 1'b0;
      bus_read(A_FLAG, rd);
      check("R2/R3/R4 vector flags", rd, {2'b00, VEC[v][5:0]});
      check("R5 vector irq", irq, |VEC[v][5:0]);
    end

    // R6 other address reads zero even with flags pending
    @(negedge clk); ext_req = 5'b11111;
    @(negedge clk); ext_req = '0;
    bus_read(16'h1004, rd);
    check("R6 other addr", rd, 8'h00);
    bus_read(A_FLAG, rd);
    check("R6 top bits zero", rd, 8'h3E);
    // R5 irq holds until the last flag is cleared
    bus_write(A_FLAG, 8'hFD);
    check("R5 irq with one left", irq, 1'b1);
    bus_write(A_FLAG, 8'hFF);
    check("R5 irq unchanged by ones", irq, 1'b1);
    bus_write(A_FLAG, 8'h00);
    check("R5 irq after last clear", irq, 1'b0);

    // R1 mid-run reset with flags set and rate 1 Hz
    bus_write(A_CTRL, 8'h02);
    @(negedge clk); ext_req = 5'b01010;
    @(negedge clk); ext_req = '0;
    do_reset();
    bus_read(A_FLAG, rd);
    check("R1 flags after reset", rd, 8'h00);

    // R9 nmi spacing, no flag or irq effect
    begin
      int n_nmi = 0;
      int n_dbl = 0;
      logic prev = 1'b0;
      @(negedge clk); tick_en = 1'b1;
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        if (nmi) n_nmi++;
        if (nmi && prev) n_dbl++;
        prev = nmi;
      end
      tick_en = 1'b0;
      check("R9 nmi count", n_nmi, 16);
      check("R9 nmi single cycle", n_dbl, 0);
      check("R9 no irq", irq, 1'b0);
      bus_read(A_FLAG, rd);
      check("R9 no flag", rd, 8'h00);
    end

    // R8 2 Hz after reset (R1 rate default): fire on strobe 128
    do_reset();
    ticks(127);
    bus_read(A_FLAG, rd);
    check("R8 2Hz before half", rd, 8'h00);
    ticks(1);
    bus_read(A_FLAG, rd);
    check("R8 2Hz at half", rd, 8'h01);
    check("R8 irq from watch", irq, 1'b1);
    bus_write(A_FLAG, 8'hFE);

    // R7 switch to 1 Hz, control reads zero
    bus_write(A_CTRL, 8'h02);
    bus_read(A_CTRL, rd);
    check("R7 ctrl reads zero", rd, 8'h00);
    ticks(127);                        // counter reaches full second
    bus_read(A_FLAG, rd);
    check("R8 1Hz before full", rd, 8'h00);
    ticks(1);
    bus_read(A_FLAG, rd);
    check("R8 1Hz at full", rd, 8'h01);
    bus_write(A_FLAG, 8'hFE);
    ticks(255);                        // passes half mark without firing
    bus_read(A_FLAG, rd);
    check("R8 1Hz skips half", rd, 8'h00);
    ticks(1);
    bus_read(A_FLAG, rd);
    check("R8 1Hz next second", rd, 8'h01);
    bus_write(A_FLAG, 8'hFE);

    // R7 reserved bits ignored: 0xFD has bit 1 clear -> 2 Hz
    bus_write(A_CTRL, 8'hFD);
    ticks(127);
    bus_read(A_FLAG, rd);
    check("R7 reserved ignored before", rd, 8'h00);
    ticks(1);
    bus_read(A_FLAG, rd);
    check("R7 reserved ignored 2Hz", rd, 8'h01);

    // R4 watch request and clear in same cycle: counter now 128, fire at 255
    ticks(127);
    @(negedge clk);
    tick_en = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    bus_read(A_FLAG, rd);
    check("R4 watch set beats clear", rd, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule